// File: doc/BRIEF.md
# USB Full-Speed Line Receiver

This block receives the two full-speed USB data lines, D+ and D-, using a sample clock that runs at several times the 12 Mbit/s bit rate. Both lines pass through a two-stage synchronizer. Each synchronized sample pair is then classified as a line state: J, K, SE0 or SE1. A line state that lasts only one sample is treated as noise and ignored. The receiver measures how many samples each accepted line state lasts. It rounds that count to whole bit times and turns the runs into NRZI-decoded bits.

Zeros inserted by the transmitter for bit stuffing are removed before output. Recovered bits leave one per cycle on a data line with a valid strobe. A start pulse marks the first K after an idle J, which is the first bit of the sync field. An SE0 that ends before the reset threshold closes the packet with an end-of-packet pulse. An SE0 that lasts up to the threshold raises a bus-reset pulse while the SE0 is still present. A run of identical line states longer than bit stuffing allows raises a one-cycle error and abandons the packet. A downstream packet engine consumes the bit stream, handles CRC and interprets the fields.

Top module: `usb_fs_line_rx`

## Requirements
- R1: After reset all output strobes are low. While the line stays in J (D+ high, D- low) and no packet is open, no bit is reported.
- R2: The first change from J to K (D+ low, D- high) with no packet open gives one `pktStart` pulse. The first bit delivered after it is a 0.
- R3: Each change between J and K is a 0 bit. Each further bit time spent in the same state is a 1 bit. Bits appear on `bitData` with `bitValid` high, one per cycle, in line order.
- R4: A run of N samples counts as floor((N + SAMPLES_PER_BIT/2) / SAMPLES_PER_BIT) bit times. With 4 samples per bit, cells of 3 or 5 samples therefore decode correctly.
- R5: A 0 that follows six consecutive 1 bits is a stuffed bit and is not delivered.
- R6: A J or K run holding more than six 1 bits (at least 8 bit times) inside a packet gives one `stuffErr` pulse. It also discards the bits not yet delivered and closes the packet, so no `eop` follows.
- R7: A line state held for a single sample, whether the opposite data state or SE0, changes no output.
- R8: An SE0 (both lines low) that ends before RESET_SAMPLES samples, while a packet is open, gives exactly one `eop` pulse.
- R9: An SE0 held for RESET_SAMPLES samples gives one `busReset` pulse. The pulse appears RESET_SAMPLES+4 clock edges after the first SE0 sample is applied, while the SE0 is still present. No `eop` follows when that SE0 ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (at least 4 samples per bit) |
| rst | input | 1 | Synchronous active-high reset |
| dPlus | input | 1 | D+ line, asynchronous |
| dMinus | input | 1 | D- line, asynchronous |
| bitValid | output | 1 | A recovered bit is on `bitData` this cycle |
| bitData | output | 1 | Recovered, unstuffed bit |
| pktStart | output | 1 | One-cycle pulse on the first K after idle |
| eop | output | 1 | One-cycle pulse when a packet's SE0 ends |
| busReset | output | 1 | One-cycle pulse once SE0 reaches the reset threshold |
| stuffErr | output | 1 | One-cycle pulse on an over-long run inside a packet |

## Verification
A line change is accepted as a state change on the fourth clock edge after it is applied. The event pulses (`pktStart`, `eop`, `stuffErr`) follow one edge later, and the first bit of a run one edge after that. The `busReset` pulse is due RESET_SAMPLES+4 edges after the first SE0 sample. Because bit delivery trails the line by a varying number of cycles, the bench records every output on the falling edge. It compares whole bit streams and pulse counts only after the packet has ended and the line has idled long enough to drain the pipeline. The reset pulse is the one result checked at an exact sample index.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  // Line state encoding is {D+, D-}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } lineState_t;

  localparam int SYNC_STAGES = 2;
  localparam int RUN_BITS_W  = 4;
  localparam int MAX_ONES    = 6;

  // Strobes from the line datapath to the bit control
  typedef struct packed {
    logic                  chg;
    lineState_t            fromState;
    lineState_t            toState;
    logic [RUN_BITS_W-1:0] runBits;
    logic                  se0Long;
  } rxEvent_t;

endpackage

// File: rtl/usbrx_linepath.sv
module usbrx_linepath
  import usbrx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int RESET_SAMPLES   = 120
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     dPlus,
  input  logic     dMinus,
  output rxEvent_t evt
);

  localparam int LONGEST = (RESET_SAMPLES > 16 * SAMPLES_PER_BIT) ?
                           RESET_SAMPLES : 16 * SAMPLES_PER_BIT;
  localparam int CNT_MAX = LONGEST + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int HALF    = SAMPLES_PER_BIT / 2;
  localparam int SAT     = (1 << RUN_BITS_W) - 1;

  logic [SYNC_STAGES-1:0] dpPipe;
  logic [SYNC_STAGES-1:0] dmPipe;
  lineState_t rawState;
  lineState_t prevRaw;
  lineState_t filtState;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W:0]   bitsWide;
  logic             confirm;

  always_ff @(posedge clk) begin
    if (rst) begin
      dpPipe    <= '1;
      dmPipe    <= '0;
      prevRaw   <= LS_J;
      filtState <= LS_J;
      runCnt    <= CNT_W'(1);
    end else begin
      dpPipe  <= {dpPipe[SYNC_STAGES-2:0], dPlus};
      dmPipe  <= {dmPipe[SYNC_STAGES-2:0], dMinus};
      prevRaw <= rawState;
      if (confirm) begin
        filtState <= rawState;
        runCnt    <= CNT_W'(1);
      end else if (runCnt != CNT_W'(CNT_MAX)) begin
        runCnt <= runCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    rawState = lineState_t'({dpPipe[SYNC_STAGES-1], dmPipe[SYNC_STAGES-1]});
    // a new state is accepted only on its second consecutive sample
    confirm  = (rawState == prevRaw) && (rawState != filtState);
    bitsWide = ({1'b0, runCnt} + (CNT_W+1)'(HALF)) / (CNT_W+1)'(SAMPLES_PER_BIT);

    evt.chg       = confirm;
    evt.fromState = filtState;
    evt.toState   = rawState;
    evt.runBits   = (bitsWide > (CNT_W+1)'(SAT)) ? RUN_BITS_W'(SAT)
                                                 : bitsWide[RUN_BITS_W-1:0];
    evt.se0Long   = (filtState == LS_SE0) && (runCnt == CNT_W'(RESET_SAMPLES));
  end

endmodule

// File: rtl/usbrx_bitctl.sv
module usbrx_bitctl
  import usbrx_pkg::*;
#(
  parameter int QUEUE_BITS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  rxEvent_t evt,
  output logic     bitValid,
  output logic     bitData,
  output logic     pktStart,
  output logic     eop,
  output logic     busReset,
  output logic     stuffErr
);

  localparam int QCW = $clog2(QUEUE_BITS + 1);

  logic [QUEUE_BITS-1:0] qData, baseData, addPat, nextData;
  logic [QCW-1:0]        qCnt, baseCnt, addLen, nextCnt;
  logic                  inPkt, nInPkt;
  logic                  emit, clearQ;
  logic                  nStart, nEop, nReset, nErr;
  logic [RUN_BITS_W-1:0] ones;
  logic                  fromData, toData;

  always_comb begin
    emit     = (qCnt != '0);
    baseData = emit ? (qData >> 1) : qData;
    baseCnt  = emit ? (qCnt - QCW'(1)) : qCnt;
    ones     = (evt.runBits != '0) ? (evt.runBits - RUN_BITS_W'(1)) : '0;
    fromData = (evt.fromState == LS_J) || (evt.fromState == LS_K);
    toData   = (evt.toState == LS_J) || (evt.toState == LS_K);
    addPat   = '0;
    addLen   = '0;
    clearQ   = 1'b0;
    nInPkt   = inPkt;
    nStart   = 1'b0;
    nEop     = 1'b0;
    nReset   = 1'b0;
    nErr     = 1'b0;

    if (evt.se0Long) begin
      nReset = 1'b1;
      nInPkt = 1'b0;
      clearQ = 1'b1;
    end else if (evt.chg) begin
      if (fromData && inPkt) begin
        if (ones > RUN_BITS_W'(MAX_ONES)) begin
          nErr   = 1'b1;
          nInPkt = 1'b0;
          clearQ = 1'b1;
        end else begin
          // ones of the finished run, then the 0 of the new transition
          addPat = (QUEUE_BITS'(1) << ones) - QUEUE_BITS'(1);
          addLen = QCW'(ones);
          if (toData && (ones != RUN_BITS_W'(MAX_ONES))) begin
            addLen = QCW'(ones) + QCW'(1);
          end
          if (evt.toState == LS_SE1) begin
            nInPkt = 1'b0;
          end
        end
      end else if (!inPkt && (evt.fromState == LS_J) && (evt.toState == LS_K)) begin
        nInPkt = 1'b1;
        nStart = 1'b1;
        addLen = QCW'(1);
      end else if (evt.fromState == LS_SE0) begin
        nEop   = inPkt;
        nInPkt = 1'b0;
      end
    end

    nextData = clearQ ? '0 : (baseData | (addPat << baseCnt));
    nextCnt  = clearQ ? '0 : (baseCnt + addLen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qData    <= '0;
      qCnt     <= '0;
      inPkt    <= 1'b0;
      bitValid <= 1'b0;
      bitData  <= 1'b0;
      pktStart <= 1'b0;
      eop      <= 1'b0;
      busReset <= 1'b0;
      stuffErr <= 1'b0;
    end else begin
      qData    <= nextData;
      qCnt     <= nextCnt;
      inPkt    <= nInPkt;
      bitValid <= emit;
      bitData  <= emit & qData[0];
      pktStart <= nStart;
      eop      <= nEop;
      busReset <= nReset;
      stuffErr <= nErr;
    end
  end

endmodule

// File: rtl/usb_fs_line_rx.sv
module usb_fs_line_rx
  import usbrx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int RESET_SAMPLES   = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic dPlus,
  input  logic dMinus,
  output logic bitValid,
  output logic bitData,
  output logic pktStart,
  output logic eop,
  output logic busReset,
  output logic stuffErr
);

  localparam int QUEUE_BITS = 16;

  rxEvent_t lineEvt;

  usbrx_linepath #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .RESET_SAMPLES  (RESET_SAMPLES)
  ) u_linepath (
    .clk   (clk),
    .rst   (rst),
    .dPlus (dPlus),
    .dMinus(dMinus),
    .evt   (lineEvt)
  );

  usbrx_bitctl #(
    .QUEUE_BITS(QUEUE_BITS)
  ) u_bitctl (
    .clk     (clk),
    .rst     (rst),
    .evt     (lineEvt),
    .bitValid(bitValid),
    .bitData (bitData),
    .pktStart(pktStart),
    .eop     (eop),
    .busReset(busReset),
    .stuffErr(stuffErr)
  );

endmodule

// File: rtl/usb_fs_line_rx_chk.sv
module usb_fs_line_rx_chk (
  input logic clk,
  input logic rst,
  input logic bitValid,
  input logic bitData,
  input logic pktStart,
  input logic eop,
  input logic busReset,
  input logic stuffErr
);

  AST_START_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    pktStart |=> (bitValid && !bitData)); // R2

  AST_ERR_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    stuffErr |=> !bitValid); // R6

  AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eop |=> !eop); // R8

  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busReset |=> !busReset); // R9

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pktStart, eop, busReset, stuffErr})); // R8

endmodule

bind usb_fs_line_rx usb_fs_line_rx_chk u_chk (.*);

// File: tb/usb_fs_line_rx_bench.sv
module usb_fs_line_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SPB        = 4;
  localparam int RST_S      = 120;
  localparam logic [1:0] LJ = 2'b10;
  localparam logic [1:0] LSE0 = 2'b00;
  // {glitch[1:0], wobble, len16, payload[15:0]}
  localparam logic [19:0] VECS [6] = '{
    20'h1C3A5, 20'h1FFFF, 20'h0007E, 20'h33CF0, 20'h50F0F, 20'hBFFFF
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dPlus = 1'b1;
  logic dMinus = 1'b0;
  logic bitValid, bitData, pktStart, eop, busReset, stuffErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_fs_line_rx #(.SAMPLES_PER_BIT(SPB), .RESET_SAMPLES(RST_S)) u_usb_fs_line_rx (
    .clk(clk), .rst(rst), .dPlus(dPlus), .dMinus(dMinus),
    .bitValid(bitValid), .bitData(bitData), .pktStart(pktStart),
    .eop(eop), .busReset(busReset), .stuffErr(stuffErr)
  );

  int checks = 0;
  int errors = 0;
  int rxCnt, startCnt, eopCnt, errCnt, resetCnt, firstRstIdx;
  int sampIdx = 0;
  int cellIdx;
  logic wobble;
  logic [1:0] cur;
  logic [63:0] rxBits;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic sampleOuts();
    if (bitValid) begin
      if (rxCnt < 64) rxBits[rxCnt] = bitData;
      rxCnt++;
    end
    if (pktStart) startCnt++;
    if (eop) eopCnt++;
    if (stuffErr) errCnt++;
    if (busReset) begin
      if (resetCnt == 0) firstRstIdx = sampIdx;
      resetCnt++;
    end
  endtask

  task automatic putSamp(input logic [1:0] s);
    {dPlus, dMinus} = s;
    @(posedge clk);
    @(negedge clk);
    sampIdx++;
    sampleOuts();
  endtask

  task automatic clearMon();
    rxCnt = 0; startCnt = 0; eopCnt = 0; errCnt = 0; resetCnt = 0;
    firstRstIdx = -1; rxBits = '0;
  endtask

  task automatic sendCell(input int glitchKind);
    int len;
    len = wobble ? (((cellIdx % 2) == 0) ? 5 : 3) : SPB;
    for (int k = 0; k < len; k++) begin
      logic [1:0] s;
      s = cur;
      if (k == 2 && cellIdx == 12) begin
        if (glitchKind == 1) s = ~cur;
        else if (glitchKind == 2) s = LSE0;
      end
      putSamp(s);
    end
    cellIdx++;
  endtask

  task automatic endPacket();
    repeat (8) putSamp(LSE0);
    repeat (12) putSamp(LJ);
  endtask

  task automatic sendPacket(input logic [15:0] payload, input int nb, input int glitchKind);
    logic [23:0] bits;
    int ones;
    bits = {payload, 8'h80};
    cur = LJ; cellIdx = 0; ones = 0;
    for (int i = 0; i < nb + 8; i++) begin
      if (!bits[i]) begin cur = ~cur; ones = 0; end
      else ones++;
      sendCell(glitchKind);
      if (ones == 6) begin
        cur = ~cur; ones = 0;
        sendCell(glitchKind);
      end
    end
    endPacket();
  endtask

  function automatic string tagFor(input logic [19:0] v);
    int run, best;
    run = 0; best = 0;
    for (int i = 0; i < 16; i++) begin
      if (v[i]) run++; else run = 0;
      if (run > best) best = run;
    end
    if (v[19:18] != 2'd0) return "R7";
    if (v[17]) return "R4";
    if (best >= 6) return "R5";
    return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    clearMon();
    wobble = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "strobes in reset", {bitValid, pktStart, eop, busReset, stuffErr}, 0);
    rst = 1'b0;
    repeat (40) putSamp(LJ);
    check("R1", "bits while idle J", rxCnt, 0);
    check("R1", "pulses while idle J", startCnt + eopCnt + errCnt + resetCnt, 0);

    // table of packets
    for (int v = 0; v < 6; v++) begin
      logic [19:0] vec;
      int nb;
      logic [23:0] expBits;
      logic [63:0] mask;
      vec = VECS[v];
      nb = vec[16] ? 16 : 8;
      wobble = vec[17];
      clearMon();
      sendPacket(vec[15:0], nb, int'(vec[19:18]));
      expBits = {vec[15:0], 8'h80};
      mask = (64'd1 << (nb + 8)) - 64'd1;
      check(tagFor(vec), $sformatf("vector %0d bit count", v), rxCnt, nb + 8);
      check(tagFor(vec), $sformatf("vector %0d bits", v), rxBits & mask, {40'd0, expBits} & mask);
      check("R2", $sformatf("vector %0d start pulses", v), startCnt, 1);
      check("R8", $sformatf("vector %0d eop pulses", v), eopCnt, 1);
      check("R6", $sformatf("vector %0d no stuff error", v), errCnt, 0);
    end
    wobble = 1'b0;

    // R6 boundary: seven ones without a transition
    clearMon();
    cur = LJ; cellIdx = 0;
    for (int i = 0; i < 7; i++) begin cur = ~cur; sendCell(0); end
    sendCell(0);
    repeat (6) sendCell(0);
    endPacket();
    check("R6", "stuff error pulses", errCnt, 1);
    check("R6", "no eop after abort", eopCnt, 0);
    check("R6", "bits before abort", rxCnt, 7);
    check("R2", "start before abort", startCnt, 1);

    // R9 bus reset timing
    clearMon();
    cur = LJ; cellIdx = 0;
    for (int i = 0; i < 7; i++) begin cur = ~cur; sendCell(0); end
    sendCell(0);
    begin
      int startIdx;
      startIdx = sampIdx + 1;
      repeat (200) putSamp(LSE0);
      repeat (12) putSamp(LJ);
      check("R9", "reset pulses", resetCnt, 1);
      check("R9", "reset pulse sample", firstRstIdx, startIdx + RST_S + 3);
    end
    check("R9", "no eop after reset", eopCnt, 0);
    check("R3", "sync bits before reset", rxBits[7:0], 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule